// File: doc/BRIEF.md
# External Interrupt and Wake Controller

This block watches a small set of external interrupt pins and keeps one latched interrupt flag for each of them. Software selects per pin whether the flag follows a level or an edge, and which polarity counts as active. A flag is cleared by writing a one to its bit. Each pin reaches the interrupt controller only when its pin-function select routes it to the interrupt function.

The block also drives two wake requests. The power-down wake request combines each pin's active condition, gated by a per-pin enable, with a real-time-clock interrupt input gated by its own enable. The deep power-down wake request is raised whenever any pin is low. No register setting can mask it, and it comes straight from the raw pins because clocks may be stopped in that state.

Registers sit on a simple synchronous bus. Writes take effect on the clock edge and reads are combinational from the address. There are four word registers: flags at offset 0x0, wake enables at 0x4, sensitivity mode at 0x8 and polarity at 0xC.

Top module: `extint_wake_ctrl`

## Requirements
- R1: After reset the mode, polarity, wake-enable and flag registers all read 0, so every pin is level-sensitive and active-low. `irqOut` and `pdWakeReq` are 0.
- R2: Each pin passes through two synchronising flops. A pin level that is present before clock edge k changes the flag on edge k+2 and no earlier.
- R3: With its mode bit at 0 (level), a pin's flag sets on every cycle in which the synchronised pin equals its polarity bit (1 = active high, 0 = active low).
- R4: With its mode bit at 1 (edge), a pin's flag sets on a synchronised rising edge when the polarity bit is 1, or on a falling edge when it is 0. The flag then holds until cleared, and the opposite edge has no effect.
- R5: Writing the flag register clears each flag whose write-data bit is 1. Bits written as 0 leave their flags unchanged.
- R6: In level mode a write-1 clear does not remove a flag while the pin stays at its active level.
- R7: `irqOut[i]` equals flag i ANDed with `pinFuncSel[i]`. The flag itself is kept when the select is 0.
- R8: `pdWakeReq` is high when any pin's set condition coincides with its wake-enable bit (bits 0..N-1 of the wake register), or when `rtcIrq` is high with wake-register bit 15 set.
- R9: `dpdWakeReq` is high whenever any raw pin is low, whatever the select, mode, polarity and wake-enable settings.
- R10: Registers decode on address bits [3:2]: 0 flags, 1 wake, 2 mode, 3 polarity. Reserved bits read 0 and ignore writes, so writing all ones to the wake register reads back 0x00008007 with three pins.
- R11: When a flag's set condition and a write-1 clear for it fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_PINS | Raw external interrupt pins |
| pinFuncSel | input | NUM_PINS | Per-pin select, 1 = routed to the interrupt function |
| rtcIrq | input | 1 | Real-time-clock interrupt, a wake source |
| busAddr | input | 4 | Byte address of the register access |
| busWe | input | 1 | Write enable, sampled on the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| irqOut | output | NUM_PINS | Interrupt requests toward the interrupt controller |
| pdWakeReq | output | 1 | Wake request out of power-down |
| dpdWakeReq | output | 1 | Unmaskable wake request out of deep power-down |

## Verification
A flag register that is wrong shows up at `irqOut` and in the flag readback in the cycle after the edge that corrupted it. A wrong synchronised or previous pin value shows up one edge later as a flag or a `pdWakeReq` that appears too early, too late or on the wrong edge. A mis-stored configuration bit shows up as soon as that register is read back, and its effect on flag setting follows two edges after the next pin change. The deep power-down request has no state at all, so any error in it is visible in the same cycle as the pin change.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int DATA_W       = 32;
  localparam int RTC_WAKE_BIT = 15;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_WAKE = 2'd1,
    SEL_MODE = 2'd2,
    SEL_POL  = 2'd3
  } regSelT;

  // strobe from the register control to the datapath
  typedef struct packed {
    logic              clrValid;
    logic [DATA_W-1:0] clrData;
  } ctrlStrobeT;

endpackage

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinFuncSel,
  input  logic                rtcIrq,
  input  logic [NUM_PINS-1:0] modeCfg,
  input  logic [NUM_PINS-1:0] polCfg,
  input  logic [NUM_PINS-1:0] wakeEn,
  input  logic                rtcWakeEn,
  input  ctrlStrobeT          strobe,
  output logic [NUM_PINS-1:0] flags,
  output logic [NUM_PINS-1:0] irqOut,
  output logic                pdWakeReq,
  output logic                dpdWakeReq
);

  logic [NUM_PINS-1:0] syncA;
  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] levelHit;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] setCond;
  logic [NUM_PINS-1:0] clrMask;
  logic [1:0]          liveCnt;
  logic                unusedClrBits;

  // Synchronisers idle high so that active-low defaults stay quiet out of reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= '1;
      pinSync <= '1;
      pinPrev <= '1;
    end else begin
      syncA   <= pinIn;
      pinSync <= syncA;
      pinPrev <= pinSync;
    end
  end

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      always_comb begin
        levelHit[i] = (pinSync[i] == polCfg[i]);
        if (polCfg[i]) edgeHit[i] = pinSync[i] & ~pinPrev[i];
        else           edgeHit[i] = ~pinSync[i] & pinPrev[i];
        setCond[i] = modeCfg[i] ? edgeHit[i] : levelHit[i];
      end

      assert_clear_R5 : assert property (@(posedge clk) disable iff (!rstN)
        (flags[i] && clrMask[i] && !setCond[i]) |=> !flags[i]);

      assert_hold_R4 : assert property (@(posedge clk) disable iff (!rstN)
        (flags[i] && !clrMask[i]) |=> flags[i]);

      assert_level_sticky_R6 : assert property (@(posedge clk) disable iff (!rstN)
        (!modeCfg[i] && levelHit[i]) |=> flags[i]);
    end
  endgenerate

  assign clrMask       = strobe.clrValid ? strobe.clrData[NUM_PINS-1:0] : '0;
  assign unusedClrBits = ^strobe.clrData[DATA_W-1:NUM_PINS];

  // set wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrMask) | setCond;
  end

  assign irqOut     = flags & pinFuncSel;
  assign pdWakeReq  = (|(setCond & wakeEn)) | (rtcIrq & rtcWakeEn);
  assign dpdWakeReq = ~(&pinIn);

  // cycles since reset, used to keep $past inside the live window
  always_ff @(posedge clk) begin
    if (!rstN)                liveCnt <= '0;
    else if (liveCnt != 2'd3) liveCnt <= liveCnt + 2'd1;
  end

  assert_sync_delay_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt == 2'd3) |-> (pinSync == $past(pinIn, 2)));

endmodule

// File: rtl/extint_regctrl.sv
module extint_regctrl
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          busAddr,
  input  logic                busWe,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [NUM_PINS-1:0] flags,
  output logic [DATA_W-1:0]   busRdata,
  output ctrlStrobeT          strobe,
  output logic [NUM_PINS-1:0] modeCfg,
  output logic [NUM_PINS-1:0] polCfg,
  output logic [NUM_PINS-1:0] wakeEn,
  output logic                rtcWakeEn
);

  regSelT regSel;
  logic   unusedAddrBits;

  assign regSel         = regSelT'(busAddr[3:2]);
  assign unusedAddrBits = ^busAddr[1:0];

  assign strobe.clrValid = busWe && (regSel == SEL_FLAG);
  assign strobe.clrData  = busWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeCfg   <= '0;
      polCfg    <= '0;
      wakeEn    <= '0;
      rtcWakeEn <= 1'b0;
    end else if (busWe) begin
      case (regSel)
        SEL_WAKE: begin
          wakeEn    <= busWdata[NUM_PINS-1:0];
          rtcWakeEn <= busWdata[RTC_WAKE_BIT];
        end
        SEL_MODE: modeCfg <= busWdata[NUM_PINS-1:0];
        SEL_POL:  polCfg  <= busWdata[NUM_PINS-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    case (regSel)
      SEL_FLAG: busRdata[NUM_PINS-1:0] = flags;
      SEL_WAKE: begin
        busRdata[NUM_PINS-1:0]   = wakeEn;
        busRdata[RTC_WAKE_BIT]   = rtcWakeEn;
      end
      SEL_MODE: busRdata[NUM_PINS-1:0] = modeCfg;
      SEL_POL:  busRdata[NUM_PINS-1:0] = polCfg;
      default:  ;
    endcase
  end

  assert_mode_write_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr[3:2] == 2'd2) |=> (modeCfg == $past(busWdata[NUM_PINS-1:0])));

  assert_wake_write_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr[3:2] == 2'd1) |=> (rtcWakeEn == $past(busWdata[RTC_WAKE_BIT])));

endmodule

// File: rtl/extint_wake_ctrl.sv
module extint_wake_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinFuncSel,
  input  logic                rtcIrq,
  input  logic [3:0]          busAddr,
  input  logic                busWe,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic [NUM_PINS-1:0] irqOut,
  output logic                pdWakeReq,
  output logic                dpdWakeReq
);

  ctrlStrobeT          strobe;
  logic [NUM_PINS-1:0] flags;
  logic [NUM_PINS-1:0] modeCfg;
  logic [NUM_PINS-1:0] polCfg;
  logic [NUM_PINS-1:0] wakeEn;
  logic                rtcWakeEn;

  extint_regctrl #(.NUM_PINS(NUM_PINS)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busWdata  (busWdata),
    .flags     (flags),
    .busRdata  (busRdata),
    .strobe    (strobe),
    .modeCfg   (modeCfg),
    .polCfg    (polCfg),
    .wakeEn    (wakeEn),
    .rtcWakeEn (rtcWakeEn)
  );

  extint_datapath #(.NUM_PINS(NUM_PINS)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .pinFuncSel (pinFuncSel),
    .rtcIrq     (rtcIrq),
    .modeCfg    (modeCfg),
    .polCfg     (polCfg),
    .wakeEn     (wakeEn),
    .rtcWakeEn  (rtcWakeEn),
    .strobe     (strobe),
    .flags      (flags),
    .irqOut     (irqOut),
    .pdWakeReq  (pdWakeReq),
    .dpdWakeReq (dpdWakeReq)
  );

  assert_dpd_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (pinIn != '1) |-> dpdWakeReq);

endmodule

// File: tb/extint_wake_ctrl_tb_top.sv
module extint_wake_ctrl_tb_top;

  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic [N-1:0] pinIn;
  logic [N-1:0] pinFuncSel;
  logic        rtcIrq;
  logic [3:0]  busAddr;
  logic        busWe;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [N-1:0] irqOut;
  logic        pdWakeReq;
  logic        dpdWakeReq;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  done     = 1'b0;

  always #4 clk = ~clk;

  extint_wake_ctrl #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinFuncSel(pinFuncSel),
    .rtcIrq(rtcIrq), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .pdWakeReq(pdWakeReq),
    .dpdWakeReq(dpdWakeReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [N-1:0] mFlag, mMode, mPol, mWake;
  logic         mRtcW;
  logic [N-1:0] hist [3];   // hist[0] newest pin sample

  function automatic logic [N-1:0] hitNow();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (!mMode[i]) r[i] = (hist[1][i] == mPol[i]);
      else if (mPol[i]) r[i] = hist[1][i] && !hist[2][i];
      else r[i] = !hist[1][i] && hist[2][i];
    end
    return r;
  endfunction

  function automatic logic [31:0] readNow(input logic [3:0] a);
    logic [31:0] r = 0;
    case (a[3:2])
      2'd0: r[N-1:0] = mFlag;
      2'd1: begin r[N-1:0] = mWake; r[15] = mRtcW; end
      2'd2: r[N-1:0] = mMode;
      default: r[N-1:0] = mPol;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mFlag = 0; mMode = 0; mPol = 0; mWake = 0; mRtcW = 0;
      for (int k = 0; k < 3; k++) hist[k] = '1;
    end else begin
      logic [N-1:0] clr;
      logic [N-1:0] hit;
      hit = hitNow();
      clr = (busWe && busAddr[3:2] == 2'd0) ? busWdata[N-1:0] : '0;
      mFlag = (mFlag & ~clr) | hit;
      if (busWe) begin
        if (busAddr[3:2] == 2'd1) begin mWake = busWdata[N-1:0]; mRtcW = busWdata[15]; end
        if (busAddr[3:2] == 2'd2) mMode = busWdata[N-1:0];
        if (busAddr[3:2] == 2'd3) mPol  = busWdata[N-1:0];
      end
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = pinIn;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN === 1'b1 && !done) begin
      check("R7 irqOut", 32'(irqOut), 32'(mFlag & pinFuncSel));
      check("R8 pdWakeReq", 32'(pdWakeReq),
            32'((|(hitNow() & mWake)) | (rtcIrq & mRtcW)));
      check("R9 dpdWakeReq", 32'(dpdWakeReq), 32'(pinIn != '1));
      check("R10 busRdata", busRdata, readNow(busAddr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; pinIn = '1; pinFuncSel = '1; rtcIrq = 1'b0;
    busAddr = 4'h0; busWe = 1'b0; busWdata = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 irqOut", 32'(irqOut), 0);
    check("R1 pdWakeReq", 32'(pdWakeReq), 0);
    check("R1 flag read", busRdata, 0);
    @(negedge clk) busAddr = 4'h8; #1 check("R1 mode read", busRdata, 0);
    busAddr = 4'h0;

    // R2 two-flop delay, default active-low level
    @(negedge clk) pinIn[0] = 1'b0;
    tick(2); check("R2 flag not yet", 32'(irqOut[0]), 0);
    tick(1); check("R2 flag on third edge", 32'(irqOut[0]), 1);
    // R6 clear ignored while level active
    busWrite(4'h0, 32'h1);
    tick(1); check("R6 level flag sticks", 32'(irqOut[0]), 1);
    check("R9 low pin wakes", 32'(dpdWakeReq), 1);
    // R8 pin wake enable
    busWrite(4'h4, 32'h1);
    tick(1); check("R8 pin wake", 32'(pdWakeReq), 1);
    @(negedge clk) pinIn[0] = 1'b1;
    tick(3); check("R8 pin wake gone", 32'(pdWakeReq), 0);
    check("R3 latched after release", 32'(irqOut[0]), 1);
    busWrite(4'h0, 32'h6);
    tick(1); check("R5 zero bit keeps flag", 32'(irqOut[0]), 1);
    busWrite(4'h0, 32'h1);
    tick(1); check("R5 write one clears", 32'(irqOut[0]), 0);
    // R8 rtc wake
    busWrite(4'h4, 32'h8000);
    @(negedge clk) rtcIrq = 1'b1;
    #1 check("R8 rtc wake", 32'(pdWakeReq), 1);
    @(negedge clk) rtcIrq = 1'b0;
    busWrite(4'h4, 32'h0);

    // R3 active-high level on pin 1
    busWrite(4'hC, 32'h2);
    tick(2); check("R3 active high sets", 32'(irqOut[1]), 1);
    @(negedge clk) pinIn[1] = 1'b0;
    tick(3); busWrite(4'h0, 32'h2);
    tick(1); check("R3 inactive then cleared", 32'(irqOut[1]), 0);
    @(negedge clk) pinIn[1] = 1'b1;

    // R4 falling edge on pin 2
    busWrite(4'h8, 32'h4);
    busWrite(4'h0, 32'h4);
    @(negedge clk) pinIn[2] = 1'b0;
    tick(3); check("R4 falling edge sets", 32'(irqOut[2]), 1);
    busWrite(4'h0, 32'h4);
    tick(1); check("R4 edge flag clears while low", 32'(irqOut[2]), 0);
    @(negedge clk) pinIn[2] = 1'b1;
    tick(4); check("R4 rising ignored", 32'(irqOut[2]), 0);

    // R11 set and clear on the same edge
    @(negedge clk) pinIn[2] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    busAddr = 4'h0; busWdata = 32'h4; busWe = 1'b1;
    @(negedge clk) busWe = 1'b0;
    #1 check("R11 set wins", 32'(irqOut[2]), 1);

    // R7 function select gating
    @(negedge clk) pinFuncSel = '0; busAddr = 4'h0;
    #1 check("R7 gated off", 32'(irqOut), 0);
    check("R7 flag kept", 32'(busRdata[2]), 1);
    @(negedge clk) pinFuncSel = '1;

    // R10 reserved bits
    busWrite(4'h4, 32'hFFFF_FFFF);
    @(negedge clk) busAddr = 4'h4;
    #1 check("R10 wake readback", busRdata, 32'h0000_8007);
    busWrite(4'hC, 32'hFFFF_FFF8);
    @(negedge clk) busAddr = 4'hC;
    #1 check("R10 pol reserved ignored", busRdata, 32'h0);
    busWrite(4'h4, 32'h0);

    // mixed traffic, compared every cycle
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      pinIn      = N'($urandom);
      pinFuncSel = N'($urandom);
      rtcIrq     = 1'($urandom);
      busAddr    = {2'($urandom), 2'b00};
      busWdata   = $urandom;
      busWe      = ($urandom_range(0, 5) == 0);
    end
    @(negedge clk) busWe = 1'b0;
    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      checkCnt++; failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule